// File: doc/BRIEF.md
# Initialization Block Fetch Sequencer

This block reads a controller's initialization block out of host memory by bus-master DMA. A `start` pulse latches a DWord-aligned base address, a layout select and a burst-enable bit. The block then fetches the block through a series of bus mastership periods. Each period asks for the bus with `bus_req`, waits for `bus_gnt`, performs exactly two DWord reads and gives the bus back. It then idles for one cycle and asks again, until the whole structure has been read.

The wide layout holds seven DWords. It takes four periods, and the eighth read lands past the end, so its data is dropped. The narrow layout takes three periods and six DWords. Each DWord that is kept is handed to the internal register file with a write strobe and a DWord index.

In non-burst mode, every read has its own address phase, and `frame` goes low between the two reads. In burst mode, a period has one address phase with the low two address bits at zero, and `frame` stays high through both data phases. A parity error reported with a data beat ends the sequence at once and raises an error pulse.

Top module: `initblk_fetch_seq`

## Requirements
- R1: After reset, `bus_req`, `frame`, `addr_valid`, `reg_we`, `done`, `err` and `busy` are all 0.
- R2: Every bus mastership period performs exactly two DWord reads. After the second read `bus_req` stays low for at least one cycle before the next request. `bus_req` drops in the cycle after the one in which `bus_gnt` is seen.
- R3: With `wide_layout`=1 the fetch uses 4 periods and 8 reads. Only DWord indices 0 to 6 are written. The eighth read produces no `reg_we`.
- R4: With `wide_layout`=0 the fetch uses 3 periods, 6 reads and writes indices 0 to 5.
- R5: In non-burst mode, every read has its own address phase. The n-th address phase of a fetch (n from 0) carries base+4n and `bus_cmd`=4'h6. `frame` is low for at least one cycle between the two reads of a period.
- R6: In burst mode, each period has a single address phase at base+8p for period p, with address bits [1:0] equal to 0 and `bus_cmd`=4'hE. `frame` stays high from that address phase until the second data beat.
- R7: The k-th DWord read (k from 0) comes from base+4k. When kept, it is written with `reg_idx`=k and `reg_data` equal to the `rd_data` that came with that beat.
- R8: `done` pulses high for exactly one cycle after the last read of a fetch without parity error. It is never high in two consecutive cycles.
- R9: A data beat with `data_rdy` and `parity_err` both high writes nothing. It ends the fetch, gives one `err` pulse and no `done`, and no further `bus_req` follows.
- R10: `start` is ignored while `busy` is high. The addresses of the running fetch do not change.
- R11: While `bus_req` is high and `bus_gnt` is low, the request is held. While in a data phase with `data_rdy` low, the block waits without advancing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a fetch (taken only when idle) |
| base_addr | input | 32 | DWord-aligned host address of the structure |
| wide_layout | input | 1 | 1: seven-DWord layout, 0: six-DWord layout |
| burst_en | input | 1 | 1: burst reads, 0: one address phase per read |
| bus_gnt | input | 1 | Bus granted |
| data_rdy | input | 1 | Read data valid this cycle |
| parity_err | input | 1 | Parity error on the current data beat |
| rd_data | input | 32 | Read data |
| bus_req | output | 1 | Bus request |
| addr_valid | output | 1 | Address phase |
| bus_addr | output | 32 | Address during the address phase |
| bus_cmd | output | 4 | Read command during the address phase (0x6 or 0xE) |
| frame | output | 1 | Transfer active (address and data phases) |
| reg_we | output | 1 | Register-file write strobe |
| reg_idx | output | 3 | DWord index being written |
| reg_data | output | 32 | DWord being written |
| done | output | 1 | Fetch completed pulse |
| err | output | 1 | Fetch aborted by parity error pulse |
| busy | output | 1 | Fetch in progress |

## Verification
A wrong period or beat cursor shows up at the next address phase as an address away from base+4n or base+8p. One address phase later it shows as a missing or extra `frame` drop. At the end it shows as the wrong number of `bus_req` rises. A wrong layout compare is seen only at the last period, as a seventh-index write that should not happen, a missing index 6, or a `done` one period early or late. A state machine that fails to release the bus shows in the cycle after the second data beat, and a mishandled abort shows as a request after `err`.

// File: rtl/initblk_pkg.sv
package initblk_pkg;
  localparam int ADDR_W = 32;
  localparam int PER_W  = 2;
  localparam int IDX_W  = PER_W + 1;

  localparam logic [3:0] CMD_RD_SINGLE = 4'h6;
  localparam logic [3:0] CMD_RD_LINE   = 4'hE;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_ADDR,
    ST_DATA,
    ST_GAP,
    ST_REL
  } fetch_st_e;

  function automatic logic [PER_W-1:0] last_period(input logic wide);
    last_period = wide ? PER_W'(3) : PER_W'(2);
  endfunction

  function automatic logic [IDX_W-1:0] kept_dwords(input logic wide);
    kept_dwords = wide ? IDX_W'(7) : IDX_W'(6);
  endfunction

  function automatic logic [ADDR_W-1:0] beat_addr(
    input logic [ADDR_W-1:0] base,
    input logic [PER_W-1:0]  per,
    input logic              beat,
    input logic              burst
  );
    logic [ADDR_W-1:0] a;
    a = {base[ADDR_W-1:2], 2'b00}
        + (ADDR_W'(per) << 3)
        + (ADDR_W'(beat) << 2);
    if (burst) a[1:0] = 2'b00;
    beat_addr = a;
  endfunction
endpackage

// File: rtl/ifs_cursor.sv
module ifs_cursor
  import initblk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             adv_beat,
  input  logic             adv_period,
  output logic [PER_W-1:0] per_idx,
  output logic             beat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_idx <= '0;
      beat    <= 1'b0;
    end else if (clear) begin
      per_idx <= '0;
      beat    <= 1'b0;
    end else if (adv_period) begin
      per_idx <= per_idx + PER_W'(1);
      beat    <= 1'b0;
    end else if (adv_beat) begin
      beat    <= 1'b1;
    end
  end
endmodule

// File: rtl/ifs_addr_gen.sv
module ifs_addr_gen
  import initblk_pkg::*;
(
  input  logic [ADDR_W-1:0] base,
  input  logic [PER_W-1:0]  per_idx,
  input  logic              beat,
  input  logic              burst,
  input  logic              phase,
  output logic [ADDR_W-1:0] addr,
  output logic [3:0]        cmd
);
  always_comb begin
    addr = '0;
    cmd  = 4'h0;
    if (phase) begin
      addr = beat_addr(base, per_idx, beat, burst);
      cmd  = burst ? CMD_RD_LINE : CMD_RD_SINGLE;
    end
  end
endmodule

// File: rtl/ifs_wr_ctl.sv
module ifs_wr_ctl
  import initblk_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             beat_good,
  input  logic [PER_W-1:0] per_idx,
  input  logic             beat,
  input  logic             wide,
  input  logic [DW-1:0]    rd_data,
  output logic             reg_we,
  output logic [IDX_W-1:0] reg_idx,
  output logic [DW-1:0]    reg_data
);
  logic [IDX_W-1:0] cur_idx;
  assign cur_idx  = {per_idx, beat};
  assign reg_we   = beat_good && (cur_idx < kept_dwords(wide));
  assign reg_idx  = reg_we ? cur_idx : '0;
  assign reg_data = reg_we ? rd_data : '0;
endmodule

// File: rtl/initblk_fetch_seq.sv
module initblk_fetch_seq
  import initblk_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              wide_layout,
  input  logic              burst_en,
  input  logic              bus_gnt,
  input  logic              data_rdy,
  input  logic              parity_err,
  input  logic [DW-1:0]     rd_data,
  output logic              bus_req,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [3:0]        bus_cmd,
  output logic              frame,
  output logic              reg_we,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [DW-1:0]     reg_data,
  output logic              done,
  output logic              err,
  output logic              busy
);
  fetch_st_e         st_q, st_d;
  logic [ADDR_W-1:0] base_q;
  logic              wide_q, burst_q;
  logic              done_q, err_q;
  logic [PER_W-1:0]  per_idx;
  logic              beat;

  // named internal events
  logic start_take, beat_accept, beat_abort, beat_good;
  logic at_last_period, period_end, seq_end;

  assign start_take     = (st_q == ST_IDLE) && start;
  assign beat_accept    = (st_q == ST_DATA) && data_rdy;
  assign beat_abort     = beat_accept && parity_err;
  assign beat_good      = beat_accept && !parity_err;
  assign at_last_period = (per_idx == last_period(wide_q));
  assign seq_end        = beat_good && beat && at_last_period;
  assign period_end     = beat_good && beat && !at_last_period;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start) st_d = ST_REQ;
      ST_REQ:  if (bus_gnt) st_d = ST_ADDR;
      ST_ADDR: st_d = ST_DATA;
      ST_DATA: begin
        if (beat_abort)      st_d = ST_IDLE;
        else if (beat_good) begin
          if (!beat)         st_d = burst_q ? ST_DATA : ST_GAP;
          else if (seq_end)  st_d = ST_IDLE;
          else               st_d = ST_REL;
        end
      end
      ST_GAP:  st_d = ST_ADDR;
      ST_REL:  st_d = ST_REQ;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      base_q  <= '0;
      wide_q  <= 1'b0;
      burst_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= seq_end;
      err_q  <= beat_abort;
      if (start_take) begin
        base_q  <= base_addr;
        wide_q  <= wide_layout;
        burst_q <= burst_en;
      end
    end
  end

  ifs_cursor u_cursor (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start_take),
    .adv_beat   (beat_good && !beat),
    .adv_period (period_end),
    .per_idx    (per_idx),
    .beat       (beat)
  );

  ifs_addr_gen u_addr (
    .base    (base_q),
    .per_idx (per_idx),
    .beat    (beat),
    .burst   (burst_q),
    .phase   (st_q == ST_ADDR),
    .addr    (bus_addr),
    .cmd     (bus_cmd)
  );

  ifs_wr_ctl #(.DW(DW)) u_wr (
    .beat_good (beat_good),
    .per_idx   (per_idx),
    .beat      (beat),
    .wide      (wide_q),
    .rd_data   (rd_data),
    .reg_we    (reg_we),
    .reg_idx   (reg_idx),
    .reg_data  (reg_data)
  );

  assign bus_req    = (st_q == ST_REQ);
  assign addr_valid = (st_q == ST_ADDR);
  assign frame      = (st_q == ST_ADDR) || (st_q == ST_DATA);
  assign done       = done_q;
  assign err        = err_q;
  assign busy       = (st_q != ST_IDLE);

  // R2: the bus is handed back after the second read of a period
  a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> !bus_req);
  // R2: request drops once the grant is taken
  a_r2_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt) |=> !bus_req);
  // R11: request is held until granted
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> bus_req);
  // R6: linear burst order in the address phase
  a_r6_burst_lowbits: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && burst_q) |-> (bus_addr[1:0] == 2'b00));
  // R3: the read past the end is never written
  a_r3_no_extra_write: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (reg_idx != IDX_W'(7)));
  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9: after an abort the bus is left alone
  a_r9_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!bus_req && !frame && !done));
endmodule

// File: tb/sim_initblk_fetch_seq.sv
`timescale 1ns/1ps
module sim_initblk_fetch_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_addr = '0;
  logic        wide_layout = 1'b0;
  logic        burst_en = 1'b0;
  logic        bus_gnt = 1'b0;
  logic        data_rdy = 1'b0;
  logic        parity_err = 1'b0;
  logic [31:0] rd_data = '0;
  logic        bus_req, addr_valid, frame, reg_we, done, err, busy;
  logic [31:0] bus_addr, reg_data;
  logic [3:0]  bus_cmd;
  logic [2:0]  reg_idx;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  initblk_fetch_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .wide_layout(wide_layout), .burst_en(burst_en), .bus_gnt(bus_gnt),
    .data_rdy(data_rdy), .parity_err(parity_err), .rd_data(rd_data),
    .bus_req(bus_req), .addr_valid(addr_valid), .bus_addr(bus_addr),
    .bus_cmd(bus_cmd), .frame(frame), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_data(reg_data), .done(done), .err(err), .busy(busy)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h0000_9E37) ^ 32'h1234_5678;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {wide, burst, base, grant wait, ready wait}
  localparam logic [41:0] VECS [5] = '{
    {1'b1, 1'b0, 32'h0000_1000, 4'd0, 4'd0},
    {1'b1, 1'b1, 32'h0004_2200, 4'd2, 4'd1},
    {1'b0, 1'b0, 32'h8000_0040, 4'd1, 4'd2},
    {1'b0, 1'b1, 32'h0000_0F00, 4'd0, 4'd3},
    {1'b1, 1'b1, 32'h7FFF_FFC0, 4'd3, 4'd0}
  };

  task automatic run_fetch(input bit wide, input bit burst, input logic [31:0] base,
                           input int gw, input int rw, input int perr_at,
                           input int restart_at);
    int periods = 0, naddr = 0, nwr = 0, nbeats = 0, falls = 0;
    int ndone = 0, nerr = 0, req_after_end = 0, gcnt = 0, rcnt = 0, tail = -1;
    bit prev_req = 1'b0, prev_frame = 1'b0, ended = 1'b0, burst_frame_ok = 1'b1;
    int exp_p = wide ? 4 : 3;
    int exp_w = wide ? 7 : 6;
    @(negedge clk);
    base_addr = base; wide_layout = wide; burst_en = burst; start = 1'b1;
    for (int cyc = 0; cyc < 400 && tail != 0; cyc++) begin
      @(negedge clk);
      start = 1'b0;
      if (cyc == restart_at) begin
        start = 1'b1; base_addr = 32'hDEAD_0000;
        wide_layout = ~wide; burst_en = ~burst;
      end
      if (bus_req) begin bus_gnt = (gcnt >= gw); gcnt++; end
      else begin bus_gnt = 1'b0; gcnt = 0; end
      if (frame && !addr_valid) begin
        data_rdy = (rcnt >= rw);
        rcnt = data_rdy ? 0 : rcnt + 1;
      end else begin
        data_rdy = 1'b0; rcnt = 0;
      end
      rd_data = mem_word(base + 32'(4 * nbeats));
      parity_err = data_rdy && (nbeats == perr_at);
      #1;
      if (bus_req && !prev_req) begin
        periods++;
        if (ended) req_after_end++;
      end
      if (addr_valid) begin
        logic [31:0] ea;
        ea = burst ? base + 32'(8 * naddr) : base + 32'(4 * naddr);
        chk(bus_addr == ea, burst ? "R6 address" : "R5 address", bus_addr, ea);
        chk(bus_cmd == (burst ? 4'hE : 4'h6), burst ? "R6 command" : "R5 command",
            32'(bus_cmd), burst ? 32'hE : 32'h6);
        naddr++;
      end
      if (prev_frame && !frame) falls++;
      if (burst && frame && !prev_frame && !addr_valid) burst_frame_ok = 1'b0;
      if (reg_we) begin
        chk(32'(reg_idx) == 32'(nwr), "R7 index", 32'(reg_idx), 32'(nwr));
        chk(reg_data == mem_word(base + 32'(4 * nwr)), "R7 data", reg_data,
            mem_word(base + 32'(4 * nwr)));
        nwr++;
      end
      if (frame && !addr_valid && data_rdy) nbeats++;
      if (done) ndone++;
      if (err) nerr++;
      if ((done || err) && !ended) begin ended = 1'b1; tail = 6; end
      else if (tail > 0) tail--;
      prev_req = bus_req; prev_frame = frame;
    end
    bus_gnt = 1'b0; data_rdy = 1'b0; parity_err = 1'b0;
    if (perr_at < 0) begin
      chk(periods == exp_p, wide ? "R3 periods" : "R4 periods", 32'(periods), 32'(exp_p));
      chk(nwr == exp_w, wide ? "R3 writes" : "R4 writes", 32'(nwr), 32'(exp_w));
      chk(nbeats == 2 * exp_p, "R2 reads", 32'(nbeats), 32'(2 * exp_p));
      chk(naddr == (burst ? exp_p : 2 * exp_p), burst ? "R6 address phases" : "R5 address phases",
          32'(naddr), 32'(burst ? exp_p : 2 * exp_p));
      chk(falls == (burst ? exp_p : 2 * exp_p), burst ? "R6 frame drops" : "R5 frame drops",
          32'(falls), 32'(burst ? exp_p : 2 * exp_p));
      chk(burst_frame_ok, "R6 frame continuity", 32'(burst_frame_ok), 32'd1);
      chk(ndone == 1, "R8 done count", 32'(ndone), 32'd1);
      chk(nerr == 0, "R8 no error", 32'(nerr), 32'd0);
    end else begin
      chk(nwr == perr_at, "R9 writes before abort", 32'(nwr), 32'(perr_at));
      chk(nerr == 1, "R9 error pulse", 32'(nerr), 32'd1);
      chk(ndone == 0, "R9 no done", 32'(ndone), 32'd0);
    end
    chk(req_after_end == 0, "R9 quiet after end", 32'(req_after_end), 32'd0);
    chk(!busy, "R2 idle at end", 32'(busy), 32'd0);
  endtask

  initial begin
    #400_000;
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk({bus_req, frame, addr_valid, reg_we, done, err, busy} == 7'b0, "R1 reset outputs",
        32'({bus_req, frame, addr_valid, reg_we, done, err, busy}), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk(!bus_req && !busy, "R1 idle after reset", 32'({bus_req, busy}), 32'd0);
    // table walk: R2 R3 R4 R5 R6 R7 R8 R11
    for (int i = 0; i < 5; i++) begin
      logic [41:0] v;
      v = VECS[i];
      run_fetch(v[41], v[40], v[39:8], int'(v[7:4]), int'(v[3:0]), -1, -1);
    end
    // R9: parity error on the fourth beat of a non-burst wide fetch
    run_fetch(1'b1, 1'b0, 32'h0000_3000, 0, 1, 3, -1);
    // R9: parity error on the very first beat of a burst fetch
    run_fetch(1'b0, 1'b1, 32'h0000_5000, 1, 0, 0, -1);
    // R10: start with other settings mid-fetch is ignored
    run_fetch(1'b0, 1'b0, 32'h0000_6000, 1, 1, -1, 7);
    // R10: and again while waiting for a grant in a later period
    run_fetch(1'b1, 1'b1, 32'h0000_7100, 3, 2, -1, 15);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule